// File: doc/BRIEF.md
# Fine-Grained Thread Issue Selector

This block decides, every clock cycle, which of several hardware thread contexts may send one instruction into a shared single-issue pipeline. Each thread presents a flag saying it has an instruction ready. The block also keeps a memory-wait bit for each thread. A stall pulse for a thread sets its bit. A memory response tagged with that thread's ID clears it. A thread takes part in selection only while it has an instruction ready and is not waiting on memory.

The choice between threads is made combinationally, inside the issue decision itself. Moving from one thread to another therefore costs no bubble, and consecutive cycles may be granted to different threads. Ties are broken by a rotating priority that begins just after the most recently granted thread, so no ready thread is starved. When no thread can issue, the block drops its grant-valid output and the pipeline takes a bubble.

Top module: `thread_issue_sel`

## Requirements
- R1: While `rst_n` is low, `grant_valid` is 0, `grant` is all zeros and `grant_tid` is 0. After the first clock edge in reset, `mem_wait` is all zeros and the rotating priority points at thread 0.
- R2: A thread can be granted only when its `inst_valid` bit is 1 and its `mem_wait` bit is 0 in the same cycle.
- R3: `grant` has at most one bit set. `grant_valid` equals the OR of `grant`. When `grant_valid` is 1, `grant_tid` is the binary index of the set bit; otherwise `grant_tid` is 0.
- R4: Among eligible threads, the grant goes to the first one found when searching upward (with wrap-around) from the thread after the last granted one. Straight after reset, the search starts at thread 0.
- R5: When no thread is eligible, `grant_valid`, `grant` and `grant_tid` are all 0.
- R6: A pulse on `stall[i]` in cycle t sets `mem_wait[i]` from cycle t+1 on. Thread i is then skipped.
- R7: `resp_valid` with `resp_tid` equal to i in cycle t clears `mem_wait[i]` from cycle t+1 on. When a response and a stall for the same thread arrive in the same cycle, the clear wins.
- R8: Switching threads adds no bubble. With all threads eligible, successive cycles grant threads 0, 1, 2, 3, 0, and so on.
- R9: A cycle without a grant leaves the rotating priority unchanged.
- R10: A response names exactly one thread. It has no effect on the `mem_wait` bit of any other thread, and a response to a thread that is not waiting leaves that bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inst_valid | input | NUM_THREADS | Per-thread instruction-ready flag |
| stall | input | NUM_THREADS | Per-thread memory-stall pulse; sets the wait bit |
| resp_valid | input | 1 | A memory response returns this cycle |
| resp_tid | input | TID_W | Thread ID carried by the memory response |
| grant | output | NUM_THREADS | One-hot issue grant |
| grant_valid | output | 1 | A thread issues this cycle |
| grant_tid | output | TID_W | Binary ID of the granted thread |
| mem_wait | output | NUM_THREADS | Current memory-wait bit of each thread |

## Verification
The bench builds the block with its default of four threads, so `grant_tid` is two bits wide. That small count makes every wrap-around of the rotating priority reachable in a few cycles. It also brings the cases where all threads are ready, where only one is ready, and where every thread is blocked on memory within a short directed sequence. Four contexts leave enough room to stall two threads at once while the other two keep issuing. The same cycles also exercise a stall arriving together with a response, and a response sent to a thread that was never waiting.

// File: rtl/thread_sel_pkg.sv
package thread_sel_pkg;

    typedef enum logic [1:0] {
        WAIT_HOLD  = 2'd0,
        WAIT_SET   = 2'd1,
        WAIT_CLEAR = 2'd2
    } wait_op_e;

endpackage

// File: rtl/thread_wait_flag.sv
module thread_wait_flag
    import thread_sel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stall_i,
    input  logic resp_i,
    output logic waiting_o
);

    typedef struct packed {
        logic waiting;
    } wstate_t;

    wstate_t  st_d, st_q;
    wait_op_e op;

    always_comb begin
        st_d = st_q;
        if (resp_i)       op = WAIT_CLEAR;
        else if (stall_i) op = WAIT_SET;
        else              op = WAIT_HOLD;
        case (op)
            WAIT_SET:   st_d.waiting = 1'b1;
            WAIT_CLEAR: st_d.waiting = 1'b0;
            default:    st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign waiting_o = st_q.waiting;

    p_stall_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && !resp_i) |=> waiting_o);

    p_resp_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_i |=> !waiting_o);

    p_quiet_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && !resp_i) |=> $stable(waiting_o));

endmodule

// File: rtl/thread_rr_picker.sv
module thread_rr_picker #(
    parameter int NUM_THREADS = 4,
    parameter int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] elig_i,
    output logic [NUM_THREADS-1:0] grant_o,
    output logic                   gvalid_o,
    output logic [TID_W-1:0]       gtid_o
);

    localparam int LAST = NUM_THREADS - 1;

    typedef struct packed {
        logic [TID_W-1:0] prio;
    } pstate_t;

    pstate_t                st_d, st_q;
    logic [NUM_THREADS-1:0] elig_m;
    logic                   found;
    logic [TID_W-1:0]       sel;
    int                     idx;

    assign elig_m = rst_n ? elig_i : '0;

    always_comb begin
        st_d    = st_q;
        found   = 1'b0;
        sel     = '0;
        idx     = 0;
        grant_o = '0;
        for (int k = 0; k < NUM_THREADS; k++) begin
            idx = int'(st_q.prio) + k;
            if (idx >= NUM_THREADS) idx = idx - NUM_THREADS;
            if (!found && elig_m[idx]) begin
                found = 1'b1;
                sel   = TID_W'(idx);
            end
        end
        if (found) begin
            grant_o[sel] = 1'b1;
            st_d.prio    = (int'(sel) == LAST) ? '0 : sel + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gvalid_o = found;
    assign gtid_o   = sel;

    p_one_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    p_valid_or_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gvalid_o == (grant_o != '0));

    p_tid_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gvalid_o |-> grant_o[gtid_o]);

    p_idle_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (elig_i == '0) |-> (!gvalid_o && gtid_o == '0));

    p_no_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gvalid_o && $past(gvalid_o) && grant_o == $past(grant_o))
            |-> ($countones(elig_i) == 1));

endmodule

// File: rtl/thread_issue_sel.sv
module thread_issue_sel #(
    parameter int NUM_THREADS = 4,
    parameter int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] inst_valid,
    input  logic [NUM_THREADS-1:0] stall,
    input  logic                   resp_valid,
    input  logic [TID_W-1:0]       resp_tid,
    output logic [NUM_THREADS-1:0] grant,
    output logic                   grant_valid,
    output logic [TID_W-1:0]       grant_tid,
    output logic [NUM_THREADS-1:0] mem_wait
);

    logic [NUM_THREADS-1:0] resp_hit;
    logic [NUM_THREADS-1:0] eligible;

    for (genvar i = 0; i < NUM_THREADS; i++) begin : g_wait
        assign resp_hit[i] = resp_valid && (resp_tid == TID_W'(i));

        thread_wait_flag u_flag (
            .clk       (clk),
            .rst_n     (rst_n),
            .stall_i   (stall[i]),
            .resp_i    (resp_hit[i]),
            .waiting_o (mem_wait[i])
        );
    end

    assign eligible = inst_valid & ~mem_wait;

    thread_rr_picker #(
        .NUM_THREADS (NUM_THREADS),
        .TID_W       (TID_W)
    ) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .elig_i   (eligible),
        .grant_o  (grant),
        .gvalid_o (grant_valid),
        .gtid_o   (grant_tid)
    );

    p_grant_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~(inst_valid & ~mem_wait)) == '0);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (!grant_valid && grant == '0));

endmodule

// File: tb/sim_thread_issue_sel.sv
module sim_thread_issue_sel;

    localparam int N  = 4;
    localparam int TW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  inst_valid = '0;
    logic [N-1:0]  stall = '0;
    logic          resp_valid = 1'b0;
    logic [TW-1:0] resp_tid = '0;
    logic [N-1:0]  grant;
    logic          grant_valid;
    logic [TW-1:0] grant_tid;
    logic [N-1:0]  mem_wait;

    always #2.5 clk = ~clk;

    thread_issue_sel #(.NUM_THREADS(N), .TID_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .stall(stall),
        .resp_valid(resp_valid), .resp_tid(resp_tid), .grant(grant),
        .grant_valid(grant_valid), .grant_tid(grant_tid), .mem_wait(mem_wait)
    );

    typedef struct {
        logic [N-1:0]  g;
        logic          gv;
        logic [TW-1:0] tid;
        logic [N-1:0]  mw;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 1'b0;

    logic [N-1:0] m_wait = '0;
    int           m_prio = 0;

    task automatic step(input logic [N-1:0] v, input logic [N-1:0] st,
                        input logic rv, input logic [TW-1:0] rt, input string tag);
        exp_t         e;
        logic [N-1:0] el;
        int           sel;
        @(negedge clk);
        inst_valid = v; stall = st; resp_valid = rv; resp_tid = rt;
        e.tag = tag; e.g = '0; e.gv = 1'b0; e.tid = '0; e.mw = m_wait;
        sel = -1;
        if (rst_n) begin
            el = v & ~m_wait;
            for (int k = 0; k < N; k++) begin
                int ix;
                ix = (m_prio + k) % N;
                if (sel < 0 && el[ix]) sel = ix;
            end
            if (sel >= 0) begin
                e.g[sel] = 1'b1; e.gv = 1'b1; e.tid = TW'(sel);
                m_prio = (sel + 1) % N;
            end
            for (int i = 0; i < N; i++) begin
                if (rv && int'(rt) == i) m_wait[i] = 1'b0;
                else if (st[i])          m_wait[i] = 1'b1;
            end
        end else begin
            m_wait = '0; m_prio = 0;
        end
        q.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                n_checks++;
                if (grant !== e.g || grant_valid !== e.gv ||
                    grant_tid !== e.tid || mem_wait !== e.mw) begin
                    n_fail++;
                    $display("FAIL %s: got grant=%b gv=%b tid=%0d wait=%b, expected grant=%b gv=%b tid=%0d wait=%b",
                             e.tag, grant, grant_valid, grant_tid, mem_wait,
                             e.g, e.gv, e.tid, e.mw);
                end
            end
        end
    end

    initial begin : watchdog
        #(200000 * 5);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : driver
        repeat (2) @(negedge clk);
        // R1: reset holds outputs quiet even with ready threads
        step(4'b1111, 4'b0000, 1'b0, 2'd0, "R1");
        step(4'b1111, 4'b1111, 1'b0, 2'd0, "R1");
        @(negedge clk);
        inst_valid = '0; stall = '0; resp_valid = 1'b0; rst_n = 1'b1;
        // R8 / R4: full rotation from thread 0, no bubbles
        for (int c = 0; c < 6; c++) step(4'b1111, 4'b0000, 1'b0, 2'd0, "R8");
        // R5 / R9: bubble, then rotation resumes where it left off
        step(4'b0000, 4'b0000, 1'b0, 2'd0, "R5");
        step(4'b0000, 4'b0000, 1'b0, 2'd0, "R9");
        step(4'b1111, 4'b0000, 1'b0, 2'd0, "R9");
        // R4: sparse patterns with wrap-around
        step(4'b0101, 4'b0000, 1'b0, 2'd0, "R4");
        step(4'b0101, 4'b0000, 1'b0, 2'd0, "R4");
        step(4'b1000, 4'b0000, 1'b0, 2'd0, "R4");
        step(4'b1000, 4'b0000, 1'b0, 2'd0, "R4");
        step(4'b0011, 4'b0000, 1'b0, 2'd0, "R4");
        // R6 / R2: stall threads 1 and 2, they get skipped
        step(4'b1111, 4'b0110, 1'b0, 2'd0, "R6");
        for (int c = 0; c < 4; c++) step(4'b1111, 4'b0000, 1'b0, 2'd0, "R2");
        // R7: response clears thread 1
        step(4'b1111, 4'b0000, 1'b1, 2'd1, "R7");
        step(4'b1111, 4'b0000, 1'b0, 2'd0, "R7");
        step(4'b1111, 4'b0000, 1'b0, 2'd0, "R7");
        // R7: stall and response for thread 2 together, clear wins
        step(4'b0100, 4'b0100, 1'b1, 2'd2, "R7");
        step(4'b0100, 4'b0000, 1'b0, 2'd0, "R7");
        // R10: response to idle thread 3 while 0 stalls; others untouched
        step(4'b0001, 4'b0001, 1'b0, 2'd0, "R6");
        step(4'b0001, 4'b0000, 1'b1, 2'd3, "R10");
        step(4'b1001, 4'b0000, 1'b0, 2'd0, "R10");
        // R5: every thread blocked on memory
        step(4'b1111, 4'b1110, 1'b0, 2'd0, "R5");
        step(4'b1111, 4'b0000, 1'b0, 2'd0, "R5");
        step(4'b1111, 4'b0000, 1'b1, 2'd3, "R5");
        step(4'b1111, 4'b0000, 1'b0, 2'd0, "R7");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule